// File: doc/BRIEF.md
# 64-bit Memory Write Target Controller

This block is the target side of a 64-bit parallel system bus for single-phase memory writes. It watches a master's cycle-frame signal. When the frame signal is low while the block is idle, it latches the address, the command and the master's request for a 64-bit transfer. The next cycle it compares the latched address against a parameterised set of address windows. If a memory write lands in one of those windows, it raises a one-hot window-select toward the local back-end, which can use that bit as a chip select. One clock later it claims the cycle with DEVSEL# using slow timing. At the same moment it asserts ACK64#, but only when the master asked for a 64-bit transfer.

Target ready (TRDY#) follows the back-end's active-low ready signal one clock late. Once asserted, TRDY# holds until the data phase finishes. The data phase finishes on the clock edge where IRDY# and TRDY# are both low. On that edge the block captures the write data and byte enables, steers them into the right half of a 64-bit local word, and presents them with a single-cycle write strobe. It then releases the bus and spends one turnaround cycle before it can decode again.

When the master did not request 64 bits, the transfer is one 32-bit word, and address bit 2 selects which half of the local word it fills. Two active-low half-select outputs tell the back-end which half or halves are active during the claimed cycle.

Top module: `qw_wr_target`

## Requirements
- R1: While reset is high and on the first cycle after it: devsel_n, trdy_n, ack64_n, lo_xfer_n, hi_xfer_n and wide_req_n are 1; range_hit is 0; wr_strobe is 0; wr_data and wr_be are 0.
- R2: When frame_n is sampled low while the block is idle, then from the next cycle loc_addr shows ad[31:0] from that edge. From that same cycle, wide_req_n shows the req64_n value from that edge, so low means a 64-bit transfer was asked for.
- R3: One cycle after loc_addr is updated, range_hit goes one-hot for a claimed write. Window 0 is 4 KiB at 0x1000_0000, window 1 is 64 KiB at 0x2000_0000, and window 2 is 1 MiB at 0x1000_0000. Where windows overlap, the lowest index wins.
- R4: Only command 4'b0111 (memory write, on cbe_n[3:0] in the address phase) to an address inside a window is claimed. Any other cycle leaves range_hit at 0 and devsel_n at 1, and leaves wr_data and wr_strobe untouched. The block then waits until frame_n and irdy_n are both sampled high before it returns to idle.
- R5: devsel_n falls exactly one clock after range_hit becomes nonzero. ack64_n falls on the same edge if req64_n was low in the address phase; otherwise it stays 1.
- R6: From the edge where devsel_n falls, trdy_n takes the value of loc_rdy_n sampled on each edge. Once trdy_n is low, it stays low until the data phase completes.
- R7: The data phase completes on the edge where irdy_n is low and trdy_n is low. In the next cycle devsel_n, trdy_n, ack64_n, lo_xfer_n, hi_xfer_n and wide_req_n are 1, and range_hit is 0.
- R8: In the cycle after completion, wr_strobe is 1 for exactly one cycle. For a 64-bit transfer, wr_data equals ad and wr_be equals ~cbe_n from the completing edge. Both values hold until the next completion.
- R9: For a 32-bit transfer with address bit 2 clear, lo_xfer_n is 0 and hi_xfer_n is 1, and the word lands as wr_data = {32'h0, ad[31:0]} with wr_be = {4'h0, ~cbe_n[3:0]}. With bit 2 set, hi_xfer_n is 0 and lo_xfer_n is 1, and the word lands as wr_data = {ad[31:0], 32'h0} with wr_be = {~cbe_n[3:0], 4'h0}. For a 64-bit transfer both half-selects are 0. Either way the half-selects are driven from the claim edge to completion.
- R10: A frame_n low sampled on the edge right after completion is not decoded, so loc_addr stays unchanged. Frame_n sampled low on the following edge is decoded again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | Cycle frame from the master, active low |
| req64_n | input | 1 | Master's 64-bit transfer request, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| ad | input | 64 | Multiplexed address/data bus |
| cbe_n | input | 8 | Command (address phase) / byte enables (data phase), active low |
| devsel_n | output | 1 | Device select claim, active low |
| trdy_n | output | 1 | Target ready, active low |
| ack64_n | output | 1 | 64-bit acknowledge, active low |
| range_hit | output | NRANGE | One-hot address window select to the back-end |
| loc_addr | output | ADDR_W | Latched transaction address |
| wide_req_n | output | 1 | Low while a 64-bit transfer is in progress |
| lo_xfer_n | output | 1 | Lower local half active, active low |
| hi_xfer_n | output | 1 | Upper local half active, active low |
| loc_rdy_n | input | 1 | Back-end ready to accept data, active low |
| wr_strobe | output | 1 | One-cycle write strobe to the back-end |
| wr_data | output | 64 | Steered write data |
| wr_be | output | 8 | Steered byte enables, active high |

## Verification
A wrong control state shows up within one or two clocks as a misplaced edge. A decode that is one state late moves the fall of devsel_n and ack64_n. A lost TRDY# hold lets trdy_n bounce back before irdy_n arrives. A missing turnaround lets loc_addr change on the edge just after completion. The bench runs a cycle-accurate model next to the block and compares every output each cycle. Any divergence in claim timing, lane choice or window priority is therefore reported in the cycle it first appears, not at the end of the transaction.

// File: rtl/qwt_pkg.sv
package qwt_pkg;

    localparam int BUS_W = 64;
    localparam int BE_W  = BUS_W / 8;

    localparam logic [3:0] CMD_MEM_WRITE = 4'b0111;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECODE,
        ST_CLAIM,
        ST_DATA,
        ST_TURN,
        ST_SKIP
    } qwt_state_e;

    typedef enum logic [1:0] {
        LANE_BOTH,
        LANE_LOW,
        LANE_HIGH
    } qwt_lane_e;

    typedef struct packed {
        logic [3:0] cmd;
        logic       wide;
    } qwt_req_t;

    typedef struct packed {
        logic [BUS_W-1:0] data;
        logic [BE_W-1:0]  be;
    } qwt_beat_t;

    function automatic logic [63:0] upper_mask(input int unsigned lg2);
        logic [63:0] m;
        m = '1;
        return m << lg2;
    endfunction

    function automatic qwt_lane_e pick_lane(input logic wide, input logic dw_sel);
        if (wide)
            return LANE_BOTH;
        else if (dw_sel)
            return LANE_HIGH;
        else
            return LANE_LOW;
    endfunction

endpackage

// File: rtl/qwt_range_decode.sv
module qwt_range_decode #(
    parameter int ADDR_W = 32,
    parameter int NRANGE = 3,
    parameter logic [NRANGE*ADDR_W-1:0] BASES = {32'h1000_0000, 32'h2000_0000, 32'h1000_0000},
    parameter logic [NRANGE*8-1:0] SPAN_LG2 = {8'd20, 8'd16, 8'd12}
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NRANGE-1:0] sel
);
    logic [NRANGE-1:0] raw;

    for (genvar g = 0; g < NRANGE; g++) begin : g_win
        localparam int unsigned LG = int'(SPAN_LG2[g*8 +: 8]);
        localparam logic [63:0] MFULL = qwt_pkg::upper_mask(LG);
        localparam logic [ADDR_W-1:0] MASK = MFULL[ADDR_W-1:0];
        localparam logic [ADDR_W-1:0] BASE = BASES[g*ADDR_W +: ADDR_W];
        assign raw[g] = ((addr ^ BASE) & MASK) == '0;
    end

    // lowest-index window wins when windows overlap
    assign sel = raw & (~raw + NRANGE'(1));

endmodule

// File: rtl/qwt_lane_steer.sv
module qwt_lane_steer
    import qwt_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [BUS_W-1:0]    ad,
    input  logic [BE_W-1:0]     cbe_n,
    input  qwt_lane_e           lane,
    input  logic                capture,
    output qwt_beat_t           beat,
    output logic                strobe
);
    qwt_beat_t nxt;
    qwt_beat_t beat_q;
    logic      stb_q;

    always_comb begin
        unique case (lane)
            LANE_LOW: begin
                nxt.data = {32'h0, ad[31:0]};
                nxt.be   = {4'h0, ~cbe_n[3:0]};
            end
            LANE_HIGH: begin
                nxt.data = {ad[31:0], 32'h0};
                nxt.be   = {~cbe_n[3:0], 4'h0};
            end
            default: begin
                nxt.data = ad;
                nxt.be   = ~cbe_n;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q <= '0;
            stb_q  <= 1'b0;
        end else begin
            stb_q <= capture;
            if (capture)
                beat_q <= nxt;
        end
    end

    assign beat   = beat_q;
    assign strobe = stb_q;

    a_r8_single_strobe: assert property (@(posedge clk) disable iff (rst)
        stb_q |=> !stb_q);

    a_r8_beat_stable_between: assert property (@(posedge clk) disable iff (rst)
        !capture |=> $stable(beat_q));

endmodule

// File: rtl/qwt_ctrl.sv
module qwt_ctrl
    import qwt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int NRANGE = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_n,
    input  logic              req64_n,
    input  logic              irdy_n,
    input  logic [ADDR_W-1:0] ad_addr,
    input  logic [3:0]        cmd,
    input  logic              loc_rdy_n,
    input  logic [NRANGE-1:0] dec_sel,
    output logic [ADDR_W-1:0] loc_addr,
    output qwt_lane_e         lane,
    output logic              capture,
    output logic              devsel_n,
    output logic              trdy_n,
    output logic              ack64_n,
    output logic              lo_xfer_n,
    output logic              hi_xfer_n,
    output logic              wide_req_n,
    output logic [NRANGE-1:0] range_hit
);
    qwt_state_e        state_q;
    qwt_req_t          req_q;
    logic [ADDR_W-1:0] addr_q;
    logic [NRANGE-1:0] hit_q;
    logic              devsel_q, trdy_q, ack_q, lo_q, hi_q, wide_n_q;
    logic              done;

    assign lane = pick_lane(req_q.wide, addr_q[2]);
    assign done = (state_q == ST_DATA) && !irdy_n && !trdy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            req_q    <= '0;
            addr_q   <= '0;
            hit_q    <= '0;
            devsel_q <= 1'b1;
            trdy_q   <= 1'b1;
            ack_q    <= 1'b1;
            lo_q     <= 1'b1;
            hi_q     <= 1'b1;
            wide_n_q <= 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (!frame_n) begin
                        addr_q     <= ad_addr;
                        req_q.cmd  <= cmd;
                        req_q.wide <= !req64_n;
                        wide_n_q   <= req64_n;
                        state_q    <= ST_DECODE;
                    end
                end
                ST_DECODE: begin
                    if (req_q.cmd == CMD_MEM_WRITE && |dec_sel) begin
                        hit_q   <= dec_sel;
                        state_q <= ST_CLAIM;
                    end else begin
                        state_q <= ST_SKIP;
                    end
                end
                ST_CLAIM: begin
                    devsel_q <= 1'b0;
                    ack_q    <= !req_q.wide;
                    lo_q     <= (lane == LANE_HIGH);
                    hi_q     <= (lane == LANE_LOW);
                    trdy_q   <= loc_rdy_n;
                    state_q  <= ST_DATA;
                end
                ST_DATA: begin
                    if (done) begin
                        devsel_q <= 1'b1;
                        trdy_q   <= 1'b1;
                        ack_q    <= 1'b1;
                        lo_q     <= 1'b1;
                        hi_q     <= 1'b1;
                        hit_q    <= '0;
                        wide_n_q <= 1'b1;
                        state_q  <= ST_TURN;
                    end else if (trdy_q) begin
                        trdy_q <= loc_rdy_n;
                    end
                end
                ST_TURN: begin
                    state_q <= ST_IDLE;
                end
                ST_SKIP: begin
                    if (frame_n && irdy_n) begin
                        wide_n_q <= 1'b1;
                        state_q  <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign loc_addr   = addr_q;
    assign capture    = done;
    assign devsel_n   = devsel_q;
    assign trdy_n     = trdy_q;
    assign ack64_n    = ack_q;
    assign lo_xfer_n  = lo_q;
    assign hi_xfer_n  = hi_q;
    assign wide_req_n = wide_n_q;
    assign range_hit  = hit_q;

    a_r3_hit_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(range_hit));

    a_r4_claim_write_only: assert property (@(posedge clk) disable iff (rst)
        $fell(devsel_n) |-> req_q.cmd == CMD_MEM_WRITE);

    a_r5_devsel_after_hit: assert property (@(posedge clk) disable iff (rst)
        $fell(devsel_n) |-> $past(|range_hit));

    a_r5_ack_within_devsel: assert property (@(posedge clk) disable iff (rst)
        !ack64_n |-> !devsel_n);

    a_r6_trdy_from_ready: assert property (@(posedge clk) disable iff (rst)
        $fell(trdy_n) |-> $past(!loc_rdy_n));

    a_r6_trdy_held: assert property (@(posedge clk) disable iff (rst)
        (!trdy_n && irdy_n) |=> !trdy_n);

    a_r7_release: assert property (@(posedge clk) disable iff (rst)
        capture |=> (devsel_n && trdy_n && ack64_n && range_hit == '0));

    a_r9_half_active: assert property (@(posedge clk) disable iff (rst)
        !devsel_n |-> (!lo_xfer_n || !hi_xfer_n));

    a_r10_turn_gap: assert property (@(posedge clk) disable iff (rst)
        $rose(devsel_n) |=> $stable(loc_addr));

endmodule

// File: rtl/qw_wr_target.sv
module qw_wr_target
    import qwt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int NRANGE = 3,
    parameter logic [NRANGE*ADDR_W-1:0] BASES = {32'h1000_0000, 32'h2000_0000, 32'h1000_0000},
    parameter logic [NRANGE*8-1:0] SPAN_LG2 = {8'd20, 8'd16, 8'd12}
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_n,
    input  logic              req64_n,
    input  logic              irdy_n,
    input  logic [63:0]       ad,
    input  logic [7:0]        cbe_n,
    output logic              devsel_n,
    output logic              trdy_n,
    output logic              ack64_n,
    output logic [NRANGE-1:0] range_hit,
    output logic [ADDR_W-1:0] loc_addr,
    output logic              wide_req_n,
    output logic              lo_xfer_n,
    output logic              hi_xfer_n,
    input  logic              loc_rdy_n,
    output logic              wr_strobe,
    output logic [63:0]       wr_data,
    output logic [7:0]        wr_be
);
    logic [NRANGE-1:0] dec_sel;
    qwt_lane_e         lane;
    logic              capture;
    qwt_beat_t         beat;

    qwt_range_decode #(
        .ADDR_W   (ADDR_W),
        .NRANGE   (NRANGE),
        .BASES    (BASES),
        .SPAN_LG2 (SPAN_LG2)
    ) u_dec (
        .addr (loc_addr),
        .sel  (dec_sel)
    );

    qwt_ctrl #(
        .ADDR_W (ADDR_W),
        .NRANGE (NRANGE)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .frame_n    (frame_n),
        .req64_n    (req64_n),
        .irdy_n     (irdy_n),
        .ad_addr    (ad[ADDR_W-1:0]),
        .cmd        (cbe_n[3:0]),
        .loc_rdy_n  (loc_rdy_n),
        .dec_sel    (dec_sel),
        .loc_addr   (loc_addr),
        .lane       (lane),
        .capture    (capture),
        .devsel_n   (devsel_n),
        .trdy_n     (trdy_n),
        .ack64_n    (ack64_n),
        .lo_xfer_n  (lo_xfer_n),
        .hi_xfer_n  (hi_xfer_n),
        .wide_req_n (wide_req_n),
        .range_hit  (range_hit)
    );

    qwt_lane_steer u_steer (
        .clk     (clk),
        .rst     (rst),
        .ad      (ad),
        .cbe_n   (cbe_n),
        .lane    (lane),
        .capture (capture),
        .beat    (beat),
        .strobe  (wr_strobe)
    );

    assign wr_data = beat.data;
    assign wr_be   = beat.be;

endmodule

// File: tb/sim_qw_wr_target.sv
`timescale 1ns/1ps
module sim_qw_wr_target;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_n = 1'b1, req64_n = 1'b1, irdy_n = 1'b1;
    logic [63:0] ad = '0;
    logic [7:0]  cbe_n = '1;
    logic        loc_rdy_n = 1'b1;
    logic        devsel_n, trdy_n, ack64_n, wide_req_n, lo_xfer_n, hi_xfer_n, wr_strobe;
    logic [2:0]  range_hit;
    logic [31:0] loc_addr;
    logic [63:0] wr_data;
    logic [7:0]  wr_be;

    int checks = 0;
    int failures = 0;
    int rdy_delay = 0;
    int bcnt = 0;
    int dev_cycles = 0;
    logic [2:0] last_hit = '0;
    logic cmp_en = 1'b0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    qw_wr_target u0 (
        .clk(clk), .rst(rst), .frame_n(frame_n), .req64_n(req64_n), .irdy_n(irdy_n),
        .ad(ad), .cbe_n(cbe_n), .devsel_n(devsel_n), .trdy_n(trdy_n), .ack64_n(ack64_n),
        .range_hit(range_hit), .loc_addr(loc_addr), .wide_req_n(wide_req_n),
        .lo_xfer_n(lo_xfer_n), .hi_xfer_n(hi_xfer_n), .loc_rdy_n(loc_rdy_n),
        .wr_strobe(wr_strobe), .wr_data(wr_data), .wr_be(wr_be)
    );

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [2:0] ref_sel(input logic [31:0] a);
        if ((a >> 12) == (32'h1000_0000 >> 12)) return 3'b001;
        if ((a >> 16) == (32'h2000_0000 >> 16)) return 3'b010;
        if ((a >> 20) == (32'h1000_0000 >> 20)) return 3'b100;
        return 3'b000;
    endfunction

    // behavioural reference model, advanced on each rising edge
    int          m_ph = 0;
    logic [31:0] m_a = '0;
    logic [3:0]  m_cmd = '0;
    logic        m_w = 1'b0;
    logic [2:0]  m_sel;
    logic        e_dev = 1, e_trdy = 1, e_ack = 1, e_lo = 1, e_hi = 1, e_wide = 1, e_stb = 0;
    logic [2:0]  e_hit = '0;
    logic [31:0] e_addr = '0;
    logic [63:0] e_data = '0;
    logic [7:0]  e_be = '0;

    always @(posedge clk) begin
        if (rst) begin
            m_ph = 0; e_dev = 1; e_trdy = 1; e_ack = 1; e_lo = 1; e_hi = 1; e_wide = 1;
            e_stb = 0; e_hit = '0; e_addr = '0; e_data = '0; e_be = '0;
        end else begin
            e_stb = 0;
            if (m_ph == 0) begin
                if (!frame_n) begin
                    m_a = ad[31:0]; m_cmd = cbe_n[3:0]; m_w = !req64_n;
                    e_addr = m_a; e_wide = req64_n; m_ph = 1;
                end
            end else if (m_ph == 1) begin
                m_sel = ref_sel(m_a);
                if (m_cmd == 4'b0111 && m_sel != 0) begin e_hit = m_sel; m_ph = 2; end
                else m_ph = 5;
            end else if (m_ph == 2) begin
                e_dev = 0; e_ack = !m_w;
                e_lo = m_w ? 1'b0 : m_a[2];
                e_hi = m_w ? 1'b0 : !m_a[2];
                e_trdy = loc_rdy_n; m_ph = 3;
            end else if (m_ph == 3) begin
                if (!irdy_n && !e_trdy) begin
                    e_stb = 1;
                    if (m_w) begin e_data = ad; e_be = ~cbe_n; end
                    else if (!m_a[2]) begin e_data = {32'h0, ad[31:0]}; e_be = {4'h0, ~cbe_n[3:0]}; end
                    else begin e_data = {ad[31:0], 32'h0}; e_be = {~cbe_n[3:0], 4'h0}; end
                    e_dev = 1; e_trdy = 1; e_ack = 1; e_lo = 1; e_hi = 1; e_hit = '0; e_wide = 1;
                    m_ph = 4;
                end else if (e_trdy) begin
                    e_trdy = loc_rdy_n;
                end
            end else if (m_ph == 4) begin
                m_ph = 0;
            end else begin
                if (frame_n && irdy_n) begin e_wide = 1; m_ph = 0; end
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_en) begin
            chk("R2", "loc_addr", 64'(loc_addr), 64'(e_addr));
            chk("R2", "wide_req_n", 64'(wide_req_n), 64'(e_wide));
            chk("R3", "range_hit", 64'(range_hit), 64'(e_hit));
            chk("R5", "devsel_n", 64'(devsel_n), 64'(e_dev));
            chk("R5", "ack64_n", 64'(ack64_n), 64'(e_ack));
            chk("R6", "trdy_n", 64'(trdy_n), 64'(e_trdy));
            chk("R9", "half selects", 64'({lo_xfer_n, hi_xfer_n}), 64'({e_lo, e_hi}));
            chk("R8", "wr_strobe", 64'(wr_strobe), 64'(e_stb));
            chk("R8", "wr_data", wr_data, e_data);
            chk("R8", "wr_be", 64'(wr_be), 64'(e_be));
            if (wr_strobe)
                chk("R7", "bus released at strobe", 64'({devsel_n, trdy_n, ack64_n, range_hit}), 64'(6'b111_000));
            if (!devsel_n) dev_cycles++;
            if (range_hit != 0) last_hit = range_hit;
        end
    end

    // back-end: ready after rdy_delay cycles of chip select
    always @(negedge clk) begin
        if (range_hit != 0) begin
            loc_rdy_n = (bcnt >= rdy_delay) ? 1'b0 : 1'b1;
            bcnt++;
        end else begin
            loc_rdy_n = 1'b1;
            bcnt = 0;
        end
    end

    task automatic txn(input logic [31:0] addr, input logic [3:0] cmd, input logic wide,
                       input logic [63:0] dat, input logic [7:0] ben, input int rdy_wait,
                       input int irdy_wait, input logic claim, input logic [2:0] exp_hit,
                       input logic probe_turn);
        int n;
        int dev_before;
        logic [63:0] old_data;
        logic [63:0] x_data;
        logic [7:0]  x_be;
        dev_before = dev_cycles;
        old_data = wr_data;
        last_hit = '0;
        rdy_delay = rdy_wait;
        @(negedge clk);
        frame_n = 1'b0; req64_n = !wide; irdy_n = 1'b1;
        ad = {32'h0, addr}; cbe_n = {4'h0, cmd};
        for (int k = 0; k < irdy_wait; k++) begin
            @(negedge clk);
            ad = dat; cbe_n = ben;
        end
        @(negedge clk);
        frame_n = 1'b1; req64_n = 1'b1; irdy_n = 1'b0; ad = dat; cbe_n = ben;
        n = 0;
        while (trdy_n !== 1'b0 && n < 12) begin
            @(negedge clk);
            n++;
        end
        @(negedge clk);
        irdy_n = 1'b1; ad = '0; cbe_n = '1;
        if (probe_turn) begin
            frame_n = 1'b0; ad = {32'h0, 32'h2000_0040}; cbe_n = 8'hF7;
            @(negedge clk);
            frame_n = 1'b1; ad = '0; cbe_n = '1;
        end
        repeat (3) @(negedge clk);
        if (claim) begin
            if (wide) begin x_data = dat; x_be = ~ben; end
            else if (!addr[2]) begin x_data = {32'h0, dat[31:0]}; x_be = {4'h0, ~ben[3:0]}; end
            else begin x_data = {dat[31:0], 32'h0}; x_be = {~ben[3:0], 4'h0}; end
            chk(wide ? "R8" : "R9", "captured data", wr_data, x_data);
            chk(wide ? "R8" : "R9", "captured be", 64'(wr_be), 64'(x_be));
            chk("R3", "window select", 64'(last_hit), 64'(exp_hit));
        end else begin
            chk("R4", "no claim cycles", 64'(dev_cycles - dev_before), 64'd0);
            chk("R4", "data untouched", wr_data, old_data);
            chk("R4", "no window select", 64'(last_hit), 64'd0);
        end
        if (probe_turn)
            chk("R10", "turnaround frame ignored", 64'(loc_addr), 64'(addr));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "reset strobes high", 64'({devsel_n, trdy_n, ack64_n, lo_xfer_n, hi_xfer_n, wide_req_n}), 64'(6'b111111));
        chk("R1", "reset hit/strobe", 64'({range_hit, wr_strobe}), 64'd0);
        chk("R1", "reset data", wr_data, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "first cycle after reset", 64'({devsel_n, trdy_n, ack64_n, wr_strobe, wr_be}), 64'({3'b111, 1'b0, 8'h00}));
        cmp_en = 1'b1;

        // overlapping windows: lowest index wins
        txn(32'h1000_0100, 4'h7, 1'b1, 64'h1122_3344_5566_7788, 8'h00, 0, 0, 1'b1, 3'b001, 1'b0);
        // only the large window, slow back-end
        txn(32'h1008_0000, 4'h7, 1'b1, 64'hDEAD_BEEF_0BAD_F00D, 8'hA5, 3, 0, 1'b1, 3'b100, 1'b0);
        // 32-bit to lower half, late initiator
        txn(32'h2000_0010, 4'h7, 1'b0, 64'h0000_0000_CAFE_0001, 8'hF2, 1, 2, 1'b1, 3'b010, 1'b0);
        // 32-bit to upper half, TRDY# waits for IRDY#
        txn(32'h2000_0014, 4'h7, 1'b0, 64'h0000_0000_ABCD_1234, 8'hF0, 0, 4, 1'b1, 3'b010, 1'b0);
        // memory read to a window: not claimed
        txn(32'h1000_0000, 4'h6, 1'b1, 64'h5555_5555_5555_5555, 8'h00, 0, 0, 1'b0, 3'b000, 1'b0);
        // write outside every window: not claimed
        txn(32'h4000_0000, 4'h7, 1'b1, 64'h6666_6666_6666_6666, 8'h00, 0, 0, 1'b0, 3'b000, 1'b0);
        // frame during turnaround must be ignored
        txn(32'h2000_0100, 4'h7, 1'b1, 64'h0102_0304_0506_0708, 8'h0F, 2, 1, 1'b1, 3'b010, 1'b1);
        // decode resumes after turnaround
        txn(32'h1000_0FF8, 4'h7, 1'b1, 64'h8877_6655_4433_2211, 8'h3C, 2, 0, 1'b1, 3'b001, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule